// File: doc/BRIEF.md
# Store Gathering Write Buffer

This block sits between a load/store unit and the write port of a 64-bit memory bus. Integer stores arrive one at a time, each with an address, a 32-bit data word, byte enables, a store kind and page attribute flags. The block keeps at most one store pending. When gathering is allowed, a second full-word store that lands in the other word of the same aligned doubleword is folded into the pending entry. The pair then leaves as a single bus write that carries the union of both byte enables. Stores may arrive in either address order.

Many stores must never be combined: partial-word stores, special store kinds, stores to guarded caching-inhibited or write-through pages, and any store made while little-endian mode or a hardware page-table walk is active. Such a store is sent to the bus alone, in program order. Three events force a pending store out: an ordering barrier, a store that cannot join it, or the gather enable being cleared. The bus side is a plain valid/ready write handshake.

Top module: `store_gather_wbuf`

## Requirements
- R1: After reset, `bus_valid` is 0 and `st_ready` is 1.
- R2: With `gather_en` set, an eligible store is held and not written to the bus until a merge, a barrier, a non-mergeable store or a cleared `gather_en` releases it.
- R3: Two eligible full-word stores (`st_be` = 4'b1111) to the two words of one 8-byte-aligned doubleword are written as one bus write with `bus_be` = 8'hFF, in whichever order they arrive. Address bit 2 = 0 uses `bus_data[31:0]` and `bus_be[3:0]`; address bit 2 = 1 uses `bus_data[63:32]` and `bus_be[7:4]`. Lanes that no store wrote are zero. `bus_addr` is the doubleword address with bits [2:0] at zero.
- R4: A store accepted while `gather_en` is 0 is never merged. Clearing `gather_en` while a store is pending raises `bus_valid` on the next cycle.
- R5: A store with both `st_guarded` and `st_inhibit` set, or with `st_wthru` set, is never merged. A store with only `st_guarded` set may still merge.
- R6: Only `st_kind` 0 (plain integer) with `st_be` = 4'b1111 may merge. Kinds 1 (byte-reversed), 2 (store-conditional), 3 (external control word) and 4 (floating point), and partial-word stores, are written alone. An accepted store that is not eligible appears on the bus the next cycle.
- R7: No store merges while `le_mode` or `walk_busy` is 1.
- R8: When `order_barrier` is high while a store is pending, that store is released the next cycle. A store presented in the same cycle as the barrier is not merged with the earlier one.
- R9: A store that cannot merge with the pending store (different doubleword, overlapping bytes, or not eligible) is stalled with `st_ready` at 0 until the pending store has been written. Bus writes therefore follow program order.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_addr`, `bus_data` and `bus_be` hold steady. Every bus write has at least one byte enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gather_en | input | 1 | Control bit that allows gathering |
| le_mode | input | 1 | Little-endian mode active; blocks gathering |
| walk_busy | input | 1 | Hardware page-table walk in progress; blocks gathering |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle when high with `st_valid` |
| st_addr | input | ADDR_W | Byte address of the store word |
| st_data | input | WORD_W | Store data |
| st_be | input | WORD_W/8 | Byte enables within the word |
| st_kind | input | 3 | 0 plain, 1 byte-reversed, 2 conditional, 3 external control, 4 floating point |
| st_guarded | input | 1 | Page is guarded |
| st_inhibit | input | 1 | Page is caching-inhibited |
| st_wthru | input | 1 | Page is write-through |
| order_barrier | input | 1 | Ordering barrier marker |
| bus_valid | output | 1 | Bus write valid |
| bus_ready | input | 1 | Bus accepts the write |
| bus_addr | output | ADDR_W | Doubleword-aligned write address |
| bus_data | output | BUS_W | Write data |
| bus_be | output | BUS_W/8 | Write byte enables |

## Verification
The bench builds the block at its defaults: a 32-bit address, 32-bit store words and a 64-bit bus. These values give exactly two word lanes per doubleword, so both arrival orders of a mergeable pair can be reached, along with an overlap on the same lane and a neighbouring doubleword. The table walks each blocking attribute, store kind and mode flag against an otherwise mergeable pair. Directed cases hold `bus_ready` low to expose the stall, the release on a cleared enable, and the barrier that arrives together with a store.

// File: rtl/sgwb_pkg.sv
// Shared types for the store gathering write buffer.
// Assumes store kinds are coded in three bits by the load/store unit.
package sgwb_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        SK_PLAIN = 3'd0,
        SK_BREV  = 3'd1,
        SK_COND  = 3'd2,
        SK_XCTL  = 3'd3,
        SK_FLOAT = 3'd4
    } st_kind_e;
endpackage

// File: rtl/sgwb_elig.sv
// Decides whether an incoming store may take part in gathering.
// Assumes all flags describe the store presented in the same cycle.
module sgwb_elig
    import sgwb_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int WBYTES = WORD_W / 8
) (
    input  logic              gather_en,
    input  logic              le_mode,
    input  logic              walk_busy,
    input  logic [KIND_W-1:0] kind,
    input  logic              guarded,
    input  logic              inhibit,
    input  logic              wthru,
    input  logic [WBYTES-1:0] be,
    output logic              elig
);
    st_kind_e kind_e;
    logic     attr_block;
    logic     mode_block;

    // Classify the store: attributes, modes, kind and width.
    always_comb begin
        kind_e     = st_kind_e'(kind);
        attr_block = (guarded && inhibit) || wthru;
        mode_block = le_mode || walk_busy || !gather_en;
        elig       = !attr_block && !mode_block && (kind_e == SK_PLAIN) && (&be);
    end
endmodule

// File: rtl/sgwb_slot.sv
// Single pending entry: captures stores, merges eligible words into the
// open doubleword, and releases the entry on the bus when it is closed.
// Assumes word-aligned store addresses and BUS_W a multiple of 2*WORD_W.
module sgwb_slot #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int BUS_W  = 64,
    localparam int WBYTES = WORD_W / 8,
    localparam int BBYTES = BUS_W / 8,
    localparam int LANES  = BUS_W / WORD_W,
    localparam int OFF_W  = $clog2(BBYTES),
    localparam int WOFF_W = $clog2(WBYTES),
    localparam int SEL_W  = OFF_W - WOFF_W,
    localparam int DW_W   = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_data,
    input  logic [WBYTES-1:0] st_be,
    input  logic              elig,
    input  logic              gather_en,
    input  logic              barrier,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_data,
    output logic [BBYTES-1:0] bus_be
);
    logic              pend_v, pend_open;
    logic [DW_W-1:0]   pend_dw;
    logic [BUS_W-1:0]  pend_data;
    logic [BBYTES-1:0] pend_be;

    logic [DW_W-1:0]   in_dw;
    logic [SEL_W-1:0]  in_sel;
    logic [BUS_W-1:0]  in_data;
    logic [BBYTES-1:0] in_be;
    logic              merge_ok, accept, drain;

    assign in_dw  = st_addr[ADDR_W-1:OFF_W];
    assign in_sel = st_addr[OFF_W-1:WOFF_W];

    // Steer the store word into its lane of the doubleword.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign in_data[l*WORD_W +: WORD_W] = (in_sel == SEL_W'(l)) ? st_data : '0;
        assign in_be[l*WBYTES +: WBYTES]   = (in_sel == SEL_W'(l)) ? st_be : '0;
    end

    // Merge test and handshake decisions.
    always_comb begin
        merge_ok = pend_v && pend_open && elig && !barrier &&
                   (in_dw == pend_dw) && ((pend_be & in_be) == '0);
        st_ready = !pend_v || merge_ok;
        accept   = st_valid && st_ready;
        drain    = pend_v && !pend_open && bus_ready;
    end

    // Pending entry: capture, merge, close and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_open <= 1'b0;
            pend_dw   <= '0;
            pend_data <= '0;
            pend_be   <= '0;
        end else begin
            if (drain) pend_v <= 1'b0;
            if (accept && !pend_v) begin
                pend_v    <= 1'b1;
                pend_dw   <= in_dw;
                pend_data <= in_data;
                pend_be   <= in_be;
                pend_open <= elig && !barrier;
            end else if (accept) begin
                pend_data <= pend_data | in_data;
                pend_be   <= pend_be | in_be;
                pend_open <= ~&(pend_be | in_be);
            end else if (pend_v && pend_open && (barrier || !gather_en || st_valid)) begin
                pend_open <= 1'b0;
            end
        end
    end

    assign bus_valid = pend_v && !pend_open;
    assign bus_addr  = {pend_dw, {OFF_W{1'b0}}};
    assign bus_data  = pend_data;
    assign bus_be    = pend_be;

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
                                    $stable(bus_data) && $stable(bus_be));
    // R10
    be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $countones(bus_be) > 0);
    // R8
    barrier_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        barrier && pend_v && !(bus_valid && bus_ready) |=> bus_valid);
    // R4
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gather_en && pend_v && !(bus_valid && bus_ready) |=> bus_valid);
    // R9
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready && !bus_valid |=> bus_valid);
endmodule

// File: rtl/store_gather_wbuf.sv
// Store gathering write buffer top: joins the eligibility decoder to the
// single pending slot. Assumes one store per cycle at most and a bus
// that honours a valid/ready handshake.
module store_gather_wbuf
    import sgwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int BUS_W  = 64,
    localparam int WBYTES = WORD_W / 8,
    localparam int BBYTES = BUS_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gather_en,
    input  logic              le_mode,
    input  logic              walk_busy,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_data,
    input  logic [WBYTES-1:0] st_be,
    input  logic [2:0]        st_kind,
    input  logic              st_guarded,
    input  logic              st_inhibit,
    input  logic              st_wthru,
    input  logic              order_barrier,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_data,
    output logic [BBYTES-1:0] bus_be
);
    logic elig;

    sgwb_elig #(.WORD_W(WORD_W)) u_elig (
        .gather_en (gather_en),
        .le_mode   (le_mode),
        .walk_busy (walk_busy),
        .kind      (st_kind),
        .guarded   (st_guarded),
        .inhibit   (st_inhibit),
        .wthru     (st_wthru),
        .be        (st_be),
        .elig      (elig)
    );

    sgwb_slot #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BUS_W(BUS_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_ready  (st_ready),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_be     (st_be),
        .elig      (elig),
        .gather_en (gather_en),
        .barrier   (order_barrier),
        .bus_valid (bus_valid),
        .bus_ready (bus_ready),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_be    (bus_be)
    );

    // R6
    inelig_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && !elig |=> bus_valid);
endmodule

// File: tb/tb_store_gather_wbuf.sv
`timescale 1ns/1ps
module tb_store_gather_wbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gather_en = 1'b1, le_mode = 1'b0, walk_busy = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0, st_data = '0;
    logic [3:0]  st_be = '0;
    logic [2:0]  st_kind = '0;
    logic        st_guarded = 1'b0, st_inhibit = 1'b0, st_wthru = 1'b0;
    logic        order_barrier = 1'b0;
    logic        bus_valid, bus_ready = 1'b1;
    logic [31:0] bus_addr;
    logic [63:0] bus_data;
    logic [7:0]  bus_be;

    int checks = 0, errors = 0;
    int nw = 0;
    logic [31:0] rec_addr [0:7];
    logic [63:0] rec_data [0:7];
    logic [7:0]  rec_be   [0:7];

    always #10 clk = ~clk;

    store_gather_wbuf dut (.*);

    typedef struct packed {
        logic [11:0] a_addr;
        logic [11:0] b_addr;
        logic [3:0]  b_be;
        logic [2:0]  b_kind;
        logic        g, ci, wt, le, walk, gen, merge;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{12'h100, 12'h104, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R3
        '{12'h104, 12'h100, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R3
        '{12'h100, 12'h108, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R9
        '{12'h100, 12'h100, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R9
        '{12'h100, 12'h104, 4'h3, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6
        '{12'h100, 12'h104, 4'hF, 3'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6
        '{12'h100, 12'h104, 4'hF, 3'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6
        '{12'h100, 12'h104, 4'hF, 3'd3, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6
        '{12'h100, 12'h104, 4'hF, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6
        '{12'h100, 12'h104, 4'hF, 3'd0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R5
        '{12'h100, 12'h104, 4'hF, 3'd0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R5
        '{12'h100, 12'h104, 4'hF, 3'd0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0}, // R5
        '{12'h100, 12'h104, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0}, // R7
        '{12'h100, 12'h104, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0}, // R7
        '{12'h100, 12'h104, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R4
        '{12'h10C, 12'h108, 4'hF, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}  // R3
    };

    // Record every completed bus write.
    always @(negedge clk) begin
        if (rst_n && bus_valid && bus_ready) begin
            if (nw < 8) begin
                rec_addr[nw] = bus_addr;
                rec_data[nw] = bus_data;
                rec_be[nw]   = bus_be;
            end
            nw = nw + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                             input logic [2:0] k, input logic g, input logic ci, input logic wt);
        @(posedge clk); #2;
        st_addr = a; st_data = d; st_be = be; st_kind = k;
        st_guarded = g; st_inhibit = ci; st_wthru = wt; st_valid = 1'b1;
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #2;
        st_valid = 1'b0;
    endtask

    task automatic pulse_barrier();
        @(posedge clk); #2 order_barrier = 1'b1;
        @(posedge clk); #2 order_barrier = 1'b0;
    endtask

    function automatic logic [7:0] lane_be(input logic [31:0] a, input logic [3:0] be);
        return a[2] ? {be, 4'h0} : {4'h0, be};
    endfunction

    function automatic logic [63:0] lane_data(input logic [31:0] a, input logic [31:0] d);
        return a[2] ? {d, 32'h0} : {32'h0, d};
    endfunction

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 bus_valid after reset", bus_valid, 0);
        check("R1 st_ready after reset", st_ready, 1);

        // Table of stimulus pairs
        for (int i = 0; i < 16; i++) begin
            vec_t v;
            logic [31:0] aa, ab, da, db;
            logic [7:0]  exp_be;
            logic [63:0] exp_data;
            v  = VECS[i];
            aa = {20'h0, v.a_addr};
            ab = {20'h0, v.b_addr};
            da = 32'h1111_0000 + i;
            db = 32'h2222_0000 + i;
            @(posedge clk); #2;
            gather_en = v.gen; le_mode = v.le; walk_busy = v.walk;
            nw = 0;
            put_store(aa, da, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0);
            put_store(ab, db, v.b_be, v.b_kind, v.g, v.ci, v.wt);
            pulse_barrier();
            repeat (4) @(negedge clk);
            if (v.merge) begin
                exp_be   = lane_be(aa, 4'hF) | lane_be(ab, v.b_be);
                exp_data = lane_data(aa, da) | lane_data(ab, db);
                check($sformatf("R3 vec%0d write count", i), nw, 1);
            end else begin
                exp_be   = lane_be(aa, 4'hF);
                exp_data = lane_data(aa, da);
                check($sformatf("R9 vec%0d write count", i), nw, 2);
                check($sformatf("R9 vec%0d second addr", i), rec_addr[1], {ab[31:3], 3'b0});
            end
            check($sformatf("R3 vec%0d first be", i), rec_be[0], exp_be);
            check($sformatf("R3 vec%0d first data", i), rec_data[0], exp_data);
            check($sformatf("R3 vec%0d first addr", i), rec_addr[0], {aa[31:3], 3'b0});
        end
        @(posedge clk); #2;
        gather_en = 1'b1; le_mode = 1'b0; walk_busy = 1'b0;

        // R2 hold, R4 release on disable, R10 stability
        nw = 0;
        put_store(32'h0000_0204, 32'hCAFE_0001, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R2 eligible store held", bus_valid, 0);
        end
        @(posedge clk); #2 bus_ready = 1'b0; gather_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R4 release after enable cleared", bus_valid, 1);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check("R10 valid held", bus_valid, 1);
            check("R10 data held", bus_data, 64'hCAFE_0001_0000_0000);
            check("R10 be held", bus_be, 8'hF0);
            check("R10 addr held", bus_addr, 32'h200);
        end
        @(posedge clk); #2 bus_ready = 1'b1; gather_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 single write", nw, 1);

        // R8 barrier releases a pending store
        nw = 0;
        put_store(32'h0000_0200, 32'hBEEF_0002, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0);
        pulse_barrier();
        @(negedge clk);
        check("R8 release after barrier", bus_valid, 1);
        check("R8 released addr", bus_addr, 32'h200);

        // R8 barrier in the same cycle as the second store
        repeat (2) @(negedge clk);
        nw = 0;
        put_store(32'h0000_0300, 32'h3333_0003, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #2;
        st_addr = 32'h0000_0304; st_data = 32'h4444_0004; st_be = 4'hF; st_kind = 3'd0;
        st_valid = 1'b1; order_barrier = 1'b1;
        @(posedge clk); #2 order_barrier = 1'b0;
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #2 st_valid = 1'b0;
        pulse_barrier();
        repeat (3) @(negedge clk);
        check("R8 same-cycle barrier count", nw, 2);
        check("R8 first write alone", rec_be[0], 8'h0F);
        check("R8 second write alone", rec_be[1], 8'hF0);

        // R9 stall while pending store cannot join
        nw = 0;
        @(posedge clk); #2 bus_ready = 1'b0;
        put_store(32'h0000_0400, 32'h5555_0005, 4'hF, 3'd0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #2;
        st_addr = 32'h0000_0800; st_data = 32'h6666_0006; st_valid = 1'b1;
        @(negedge clk);
        check("R9 stalled on mismatch", st_ready, 0);
        @(posedge clk);
        @(negedge clk);
        check("R9 still stalled", st_ready, 0);
        check("R9 pending released", bus_valid, 1);
        @(posedge clk); #2 bus_ready = 1'b1;
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #2 st_valid = 1'b0;
        pulse_barrier();
        repeat (3) @(negedge clk);
        check("R9 write count", nw, 2);
        check("R9 order first", rec_addr[0], 32'h400);
        check("R9 order second", rec_addr[1], 32'h800);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule